// File: doc/BRIEF.md
# Time-Multiplexed Polynomial-Branch FIR Filter

This block evaluates a tunable FIR filter built from several polynomial subfilter branches using a single shared multiplier and a single wide accumulator. Two nested counters walk every tap (inner) of every branch (outer). For each step the counters address a computed coefficient ROM and select one sample of the input delay line through a multiplexer. The product enters a registered multiply stage and then a registered accumulate stage. When the final product of a frame has been summed, the full-width result is written to the output and a one-cycle valid pulse is raised. The accumulator is then cleared for the next frame.

The outer counter restarts at a programmable starting branch rather than at zero. Raising the starting branch drops the lower branches from the sum and shortens the frame. New input samples are taken into the delay line only at frame boundaries, so every product of one frame uses the same set of delayed samples. A sample that arrives mid-frame waits in a one-deep holding register. The system clock is assumed to run far faster than the sample rate.

Top module: `poly_mac_fir`

## Requirements
- R1: While reset is high, and after it is released with enable low, `y_out` is 0 and `y_valid` is 0.
- R2: `y_valid` is a single-cycle pulse. With enable held high it recurs every N_TAPS×(N_BRANCH−b0) cycles, where b0 is the starting branch in effect for that frame.
- R3: On a pulse, `y_out` equals the exact two's complement sum over branches b0..N_BRANCH−1 and taps t of coef(b,t)×x[t], sign-extended to ACC_W bits. Here x[t] is the delay-line sample t positions old, captured at the start of the frame.
- R4: The coefficient for branch b and tap t is ((53·b + 29·t + 7) mod 509)·64 − 16256, as a 16-bit signed value.
- R5: After reset the branch index starts at 0. At the end of every frame it reloads `start_br`, or N_BRANCH−1 when `start_br` exceeds N_BRANCH−1. The tap and branch indices never leave their ranges.
- R6: A strobed sample enters delay-line position 0 only on the enabled cycle that closes a frame. One strobed mid-frame waits in a one-deep buffer, and a later mid-frame strobe replaces it. If the buffer is full on the closing cycle, the buffered sample is shifted in and a strobe on that same cycle refills the buffer.
- R7: `y_out` changes only on cycles where `y_valid` is high and holds its value between pulses.
- R8: While `en` is low, the counters, the delay-line shift and the pipeline stages all hold, and no pulse is produced. Each low cycle delays the next pulse by one cycle.
- R9: With enable high from reset release and `start_br` = 0, the first pulse appears after the (N_TAPS×N_BRANCH + 2)-th rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advances counters and pipeline when high |
| smp_in | input | DW | Signed input sample |
| smp_stb | input | 1 | Marks `smp_in` as a new sample |
| start_br | input | clog2(N_BRANCH) | Branch index loaded at each frame restart |
| y_out | output | ACC_W | Full-width signed filter result |
| y_valid | output | 1 | One-cycle pulse when `y_out` is updated |

## Verification
Two events can land on the same edge. The first is a sample strobe on the frame-closing cycle while the holding buffer is already full, so one edge both shifts the delay line and refills the buffer. The second is enable falling while the last products of a frame are still in the multiply and accumulate stages. Random strobe timing and random enable gaps provoke both cases. A behavioural model that tracks the buffer, the delay line and a latency countdown in enabled cycles predicts the result, and its value and pulse timing are compared with the ports on every cycle.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    localparam int COEF_W = 16;

    // Computed coefficient table: branch b, tap t
    function automatic logic signed [COEF_W-1:0] pmf_coef(input int unsigned br, input int unsigned tap);
        int unsigned raw;
        logic signed [31:0] v;
        raw = (br * 32'd53 + tap * 32'd29 + 32'd7) % 32'd509;
        v   = $signed(raw * 32'd64) - 32'sd16256;
        return v[COEF_W-1:0];
    endfunction

endpackage

// File: rtl/pmf_sequencer.sv
module pmf_sequencer #(
    parameter int N_TAPS   = 80,
    parameter int N_BRANCH = 12,
    localparam int TW = $clog2(N_TAPS),
    localparam int BW = $clog2(N_BRANCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [BW-1:0] start_br,
    output logic [TW-1:0] tap_q,
    output logic [BW-1:0] br_q,
    output logic          frame_end
);

    typedef struct packed {
        logic [TW-1:0] tap;
        logic [BW-1:0] br;
    } seq_t;

    seq_t s_d, s_q;
    logic          last_tap;
    logic [BW-1:0] start_cl;

    always_comb begin
        last_tap  = (s_q.tap == TW'(N_TAPS - 1));
        frame_end = last_tap && (s_q.br == BW'(N_BRANCH - 1));
        start_cl  = (start_br > BW'(N_BRANCH - 1)) ? BW'(N_BRANCH - 1) : start_br;
        s_d = s_q;
        if (en) begin
            if (last_tap) begin
                s_d.tap = '0;
                s_d.br  = frame_end ? start_cl : s_q.br + BW'(1);
            end else begin
                s_d.tap = s_q.tap + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign tap_q = s_q.tap;
    assign br_q  = s_q.br;

endmodule

// File: rtl/pmf_delay_line.sv
module pmf_delay_line #(
    parameter int N_TAPS = 80,
    parameter int DW     = 16,
    localparam int TW = $clog2(N_TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  logic [DW-1:0] in_data,
    input  logic          in_stb,
    input  logic [TW-1:0] sel,
    output logic [DW-1:0] tap_data
);

    typedef struct packed {
        logic [N_TAPS-1:0][DW-1:0] line;
        logic                      pend;
        logic [DW-1:0]             pend_data;
    } dl_t;

    dl_t d, q;

    always_comb begin
        d = q;
        if (shift && (q.pend || in_stb)) begin
            d.line[0] = q.pend ? q.pend_data : in_data;
            for (int k = 1; k < N_TAPS; k++) begin
                d.line[k] = q.line[k-1];
            end
        end
        if (shift) begin
            if (q.pend) begin
                d.pend = in_stb;
                if (in_stb) d.pend_data = in_data;
            end
        end else if (in_stb) begin
            d.pend      = 1'b1;
            d.pend_data = in_data;
        end
        tap_data = q.line[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/pmf_coef_rom.sv
module pmf_coef_rom #(
    parameter int N_TAPS   = 80,
    parameter int N_BRANCH = 12,
    localparam int TW = $clog2(N_TAPS),
    localparam int BW = $clog2(N_BRANCH),
    localparam int CW = pmf_pkg::COEF_W
) (
    input  logic [TW-1:0] tap,
    input  logic [BW-1:0] br,
    output logic [CW-1:0] coef
);

    always_comb begin
        coef = pmf_pkg::pmf_coef(32'(br), 32'(tap));
    end

endmodule

// File: rtl/pmf_mac_pipe.sv
module pmf_mac_pipe #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 40,
    localparam int PW = AW + CW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             issue_last,
    input  logic [AW-1:0]    op_a,
    input  logic [CW-1:0]    op_b,
    output logic [ACC_W-1:0] y,
    output logic             y_vld
);

    typedef struct packed {
        logic [AW-1:0]    a;
        logic [CW-1:0]    b;
        logic             l1;
        logic [PW-1:0]    p;
        logic             l2;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] y;
        logic             vld;
    } mac_t;

    mac_t d, q;
    logic signed [PW-1:0]    prod;
    logic        [ACC_W-1:0] sum;

    always_comb begin
        prod  = $signed(q.a) * $signed(q.b);
        sum   = q.acc + {{(ACC_W-PW){q.p[PW-1]}}, q.p};
        d     = q;
        d.vld = 1'b0;
        if (en) begin
            d.a  = op_a;
            d.b  = op_b;
            d.l1 = issue_last;
            d.p  = prod;
            d.l2 = q.l1;
            if (q.l2) begin
                d.y   = sum;
                d.vld = 1'b1;
                d.acc = '0;
            end else begin
                d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign y     = q.y;
    assign y_vld = q.vld;

endmodule

// File: rtl/poly_mac_fir.sv
module poly_mac_fir #(
    parameter int N_TAPS   = 80,
    parameter int N_BRANCH = 12,
    parameter int DW       = 16,
    parameter int ACC_W    = 40,
    localparam int TW = $clog2(N_TAPS),
    localparam int BW = $clog2(N_BRANCH),
    localparam int CW = pmf_pkg::COEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DW-1:0]    smp_in,
    input  logic             smp_stb,
    input  logic [BW-1:0]    start_br,
    output logic [ACC_W-1:0] y_out,
    output logic             y_valid
);

    logic [TW-1:0] tap_idx;
    logic [BW-1:0] br_idx;
    logic          frame_end;
    logic [DW-1:0] tap_data;
    logic [CW-1:0] coef;

    pmf_sequencer #(.N_TAPS(N_TAPS), .N_BRANCH(N_BRANCH)) u_seq (
        .clk(clk), .rst(rst), .en(en), .start_br(start_br),
        .tap_q(tap_idx), .br_q(br_idx), .frame_end(frame_end)
    );

    pmf_delay_line #(.N_TAPS(N_TAPS), .DW(DW)) u_dl (
        .clk(clk), .rst(rst), .shift(en && frame_end),
        .in_data(smp_in), .in_stb(smp_stb), .sel(tap_idx), .tap_data(tap_data)
    );

    pmf_coef_rom #(.N_TAPS(N_TAPS), .N_BRANCH(N_BRANCH)) u_rom (
        .tap(tap_idx), .br(br_idx), .coef(coef)
    );

    pmf_mac_pipe #(.AW(DW), .CW(CW), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst(rst), .en(en), .issue_last(frame_end),
        .op_a(tap_data), .op_b(coef), .y(y_out), .y_vld(y_valid)
    );

endmodule

// File: rtl/poly_mac_fir_chk.sv
module poly_mac_fir_chk #(
    parameter int N_TAPS   = 80,
    parameter int N_BRANCH = 12,
    parameter int ACC_W    = 40,
    localparam int TW = $clog2(N_TAPS),
    localparam int BW = $clog2(N_BRANCH)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [BW-1:0]    start_br,
    input logic [ACC_W-1:0] y_out,
    input logic             y_valid,
    input logic [TW-1:0]    tap_q,
    input logic [BW-1:0]    br_q
);

    function automatic logic [BW-1:0] clamp_br(input logic [BW-1:0] s);
        return (s > BW'(N_BRANCH - 1)) ? BW'(N_BRANCH - 1) : s;
    endfunction

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) y_valid |=> !y_valid); // R2
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst) !y_valid |-> $stable(y_out)); // R7
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) y_valid |-> $past(en)); // R8
    AST_FREEZE_COUNTERS: assert property (@(posedge clk) disable iff (rst) (!en && !rst) |=> ($stable(tap_q) && $stable(br_q))); // R8
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst) (32'(tap_q) < N_TAPS) && (32'(br_q) < N_BRANCH)); // R5
    AST_BRANCH_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (en && !rst && tap_q == TW'(N_TAPS - 1) && br_q == BW'(N_BRANCH - 1))
        |=> (br_q == clamp_br($past(start_br)) && tap_q == '0)); // R5

endmodule

bind poly_mac_fir poly_mac_fir_chk #(.N_TAPS(N_TAPS), .N_BRANCH(N_BRANCH), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .start_br(start_br), .y_out(y_out),
    .y_valid(y_valid), .tap_q(tap_idx), .br_q(br_idx)
);

// File: tb/tb_poly_mac_fir.sv
module tb_poly_mac_fir;

    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int NB  = 3;
    localparam int DW  = 16;
    localparam int AW  = 40;
    localparam int BWI = $clog2(NB);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en  = 1'b0;
    logic           stb = 1'b0;
    logic [DW-1:0]  din = '0;
    logic [BWI-1:0] start = '0;
    logic [AW-1:0]  y;
    logic           yv;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poly_mac_fir #(.N_TAPS(NT), .N_BRANCH(NB), .DW(DW), .ACC_W(AW)) dut (
        .clk(clk), .rst(rst), .en(en), .smp_in(din), .smp_stb(stb),
        .start_br(start), .y_out(y), .y_valid(yv)
    );

    // R4 coefficient rule, written from the requirement
    function automatic longint bcoef(input int b, input int t);
        return longint'(((b * 53 + t * 29 + 7) % 509) * 64 - 16256);
    endfunction

    function automatic int clampb(input int s);
        return (s > NB - 1) ? NB - 1 : s;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference
    int     m_tap, m_br, m_rem;
    longint m_acc, m_pdata, m_res, e_y;
    longint m_dl[NT];
    bit     m_pend, m_fly, e_vld, fe;

    always @(posedge clk) begin
        if (rst) begin
            m_tap = 0; m_br = 0; m_acc = 0; m_pend = 0; m_pdata = 0;
            m_fly = 0; m_rem = 0; m_res = 0; e_vld = 0; e_y = 0;
            for (int k = 0; k < NT; k++) m_dl[k] = 0;
        end else begin
            e_vld = 0;
            fe = en && (m_tap == NT - 1) && (m_br == NB - 1);
            if (en && m_fly) begin
                m_rem--;
                if (m_rem == 0) begin e_vld = 1; e_y = m_res; m_fly = 0; end
            end
            if (en) begin
                m_acc += bcoef(m_br, m_tap) * m_dl[m_tap];
                if (fe) begin m_fly = 1; m_rem = 2; m_res = m_acc; m_acc = 0; end
                if (m_tap == NT - 1) begin
                    m_tap = 0;
                    m_br  = fe ? clampb(int'(start)) : m_br + 1;
                end else m_tap++;
            end
            if (fe) begin
                if (m_pend || stb) begin
                    for (int k = NT - 1; k > 0; k--) m_dl[k] = m_dl[k-1];
                    m_dl[0] = m_pend ? m_pdata : longint'($signed(din));
                end
                if (m_pend) begin
                    m_pend = stb;
                    if (stb) m_pdata = longint'($signed(din));
                end
            end else if (stb) begin
                m_pend = 1; m_pdata = longint'($signed(din));
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !rst) begin
            check(yv == e_vld, "R2 pulse timing", longint'(yv), longint'(e_vld));
            if (e_vld)
                check(y == AW'(e_y), "R3 frame result", longint'($signed(y)), e_y);
            else
                check(y == AW'(e_y), "R7 output hold", longint'($signed(y)), e_y);
        end
    end

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!yv && n < 1000);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        longint ysave, imp;
        repeat (3) @(negedge clk);
        check(y == '0 && !yv, "R1 reset state", longint'(y), 0);
        rst = 1'b0;
        @(negedge clk);
        check(y == '0 && !yv, "R1 idle after release", longint'(y), 0);
        chk_on = 1'b1;
        // R9 first pulse latency, with a mid-frame strobe (R6)
        en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            stb = (n == 5);
            din = 16'd1;
        end while (!yv && n < 1000);
        stb = 1'b0;
        check(n == NT * NB + 2, "R9 first pulse edge", n, NT * NB + 2);
        check(y == '0, "R6 mid-frame sample not used by current frame", longint'(y), 0);
        wait_pulse(n);
        check(n == NT * NB, "R2 frame period", n, NT * NB);
        imp = 0;
        for (int b = 0; b < NB; b++) imp += bcoef(b, 0);
        check(y == AW'(imp), "R4 impulse response", longint'($signed(y)), imp);

        // Random traffic: strobes, extremes, enable gaps, start changes
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            stb = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: din = 16'h8000;
                1: din = 16'h7fff;
                default: din = DW'($urandom);
            endcase
            en = ($urandom % 8) != 0;
            if (($urandom % 50) == 0) start = BWI'($urandom);
        end
        @(negedge clk);
        stb = 1'b0; en = 1'b1;

        // R5 start index and clamp
        start = 2'd1;
        wait_pulse(n); wait_pulse(n); wait_pulse(n);
        check(n == NT * (NB - 1), "R5 start=1 period", n, NT * (NB - 1));
        start = 2'd3;
        wait_pulse(n); wait_pulse(n); wait_pulse(n);
        check(n == NT * (NB - clampb(3)), "R5 clamped start period", n, NT * (NB - clampb(3)));
        start = 2'd1;
        wait_pulse(n); wait_pulse(n); wait_pulse(n);

        // R8 enable gap freezes everything
        repeat (3) @(negedge clk);
        en = 1'b0;
        ysave = longint'(y);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!yv && longint'(y) == ysave, "R8 frozen while disabled", longint'(yv), 0);
        end
        en = 1'b1;
        wait_pulse(n);
        check(n + 13 == NT * (NB - 1) + 10, "R8 gap extends period", n + 13, NT * (NB - 1) + 10);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule